// File: doc/BRIEF.md
# I2C Target with Register Array Access

This block lets a bus master read and write a small byte-wide register array through the two-wire I2C bus. The block is a target on that bus. The master first sends a frame with the seven-bit device address and a direction bit. In a write, the next byte is a word address that loads an internal pointer. Each following byte is stored at the pointer, and the pointer then advances. In a read, bytes are returned from the pointer. The pointer advances after every byte the master acknowledges. It rolls over from the last location to zero, so one read can stream the whole array and continue.

A random read is a write frame that carries only the word address. A repeated START with the read bit follows it, with no STOP between them. A current-address read skips the word address and uses the pointer value left by the previous transfer. The bus pins appear as synchronized inputs plus a drive-low enable for SDA. The array sits outside the block, behind a synchronous port: the address is continuous, the write strobe lasts one cycle, and read data arrives one cycle after the address.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset `sda_oe_o` and `mem_we_o` are low. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After a STOP the block is idle and waits for a START.
- R2: The first byte after a START holds the device address in bits 7..1 and the direction in bit 0 (1 = read). If bits 7..1 equal `DEV_ADDR`, the block drives SDA low during the ninth clock. Otherwise it neither acknowledges nor drives SDA nor writes the array until the next START.
- R3: In a write, the byte after the address frame loads the pointer and stores nothing. Every later byte is acknowledged and written at the pointer with a one-cycle `mem_we_o` pulse.
- R4: The pointer advances by one after each stored byte and after each read byte the master acknowledges. It wraps from 2**ADDR_W-1 to 0.
- R5: A repeated START with the read bit, given right after the word-address acknowledge, is acknowledged. The first byte returned is the one at the just-loaded pointer.
- R6: The pointer keeps its value between transfers. A read that starts without a word address returns data from that retained value.
- R7: Read bytes are sent MSB first, and SDA is released during the ninth clock. On an acknowledge from the master, the byte at the next pointer value follows. A single read can stream past the end of the array.
- R8: After the master NACKs a byte, the block drives SDA no more in that transfer, and the NACKed byte does not advance the pointer.
- R9: `sda_oe_o` changes only while the synchronized SCL is low.
- R10: A START or STOP inside a byte aborts the transfer, and a partly received byte is not stored. After a START, the block decodes a fresh address frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Pull SDA low when high |
| mem_addr_o | output | ADDR_W | Array address (the pointer) |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the address |

## Verification
The bench builds the block with ADDR_W = 4 and DEV_ADDR = 0x52. With only 16 locations, both a four-byte write and an 18-byte sequential read cross the wrap from the last address to zero inside a short run. The address-mismatch case uses 0x53, which differs from the configured address in its lowest address bit only, so a compare of the wrong width or alignment is exposed. SCL runs at 40 system clocks per period. This leaves the synchronizer delay well inside each quarter period, so every SDA sample at the master side lands on a settled value.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[TOP-1:0], scl_i};
      sda_ff <= {sda_ff[TOP-1:0], sda_i};
      scl_q  <= scl_ff[TOP];
      sda_q  <= sda_ff[TOP];
    end
  end

  assign scl_o      = scl_ff[TOP];
  assign sda_o      = sda_ff[TOP];
  assign scl_rise_o = scl_ff[TOP] & ~scl_q;
  assign scl_fall_o = ~scl_ff[TOP] & scl_q;
  // bus conditions need SCL high on both samples
  assign start_o    = scl_ff[TOP] & scl_q & sda_q & ~sda_ff[TOP];
  assign stop_o     = scl_ff[TOP] & scl_q & ~sda_q & sda_ff[TOP];
endmodule

// File: rtl/i2c_addr_ptr.sv
module i2c_addr_ptr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h52,
  parameter int         ADDR_W      = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam int DATA_W = 8;
  localparam int BIT_W  = $clog2(DATA_W + 1);
  localparam logic [BIT_W-1:0] FULL = BIT_W'(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  tgt_state_e state_q;
  logic [BIT_W-1:0]  bitcnt_q;
  logic [DATA_W-1:0] shreg_q, wdata_q;
  logic sda_oe_q, we_q, rd_q, mack_q;
  logic ptr_load, ptr_inc;
  logic [ADDR_W-1:0] ptr;

  i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  always_comb begin
    ptr_load = (state_q == ST_WADDR) && scl_fall && (bitcnt_q == FULL);
    ptr_inc  = we_q || ((state_q == ST_RACK) && scl_rise && !sda_s);
  end

  i2c_addr_ptr #(.ADDR_W(ADDR_W)) ptr_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ptr_load),
    .load_val_i(shreg_q[ADDR_W-1:0]), .inc_i(ptr_inc), .ptr_o(ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      wdata_q  <= '0;
      sda_oe_q <= 1'b0;
      we_q     <= 1'b0;
      rd_q     <= 1'b0;
      mack_q   <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (stop_c) begin
        state_q  <= ST_IDLE;
        sda_oe_q <= 1'b0;
      end else if (start_c) begin
        state_q  <= ST_DEV;
        bitcnt_q <= '0;
        sda_oe_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise && bitcnt_q != FULL) begin
              shreg_q  <= {shreg_q[DATA_W-2:0], sda_s};
              bitcnt_q <= bitcnt_q + 1'b1;
            end else if (scl_fall && bitcnt_q == FULL) begin
              if (state_q == ST_DEV) begin
                if (shreg_q[7:1] == DEV_ADDR) begin
                  sda_oe_q <= 1'b1;
                  rd_q     <= shreg_q[0];
                  state_q  <= ST_DEV_ACK;
                end else begin
                  state_q  <= ST_IGNORE;
                end
              end else if (state_q == ST_WADDR) begin
                sda_oe_q <= 1'b1;
                state_q  <= ST_WADDR_ACK;
              end else begin
                sda_oe_q <= 1'b1;
                we_q     <= 1'b1;
                wdata_q  <= shreg_q;
                state_q  <= ST_WDATA_ACK;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              bitcnt_q <= '0;
              if (rd_q) begin
                shreg_q  <= mem_rdata_i;
                sda_oe_q <= ~mem_rdata_i[DATA_W-1];
                state_q  <= ST_RDATA;
              end else begin
                sda_oe_q <= 1'b0;
                state_q  <= ST_WADDR;
              end
            end
          end
          ST_WADDR_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe_q <= 1'b0;
              bitcnt_q <= '0;
              state_q  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bitcnt_q == LAST_BIT) begin
                sda_oe_q <= 1'b0;
                bitcnt_q <= '0;
                state_q  <= ST_RACK;
              end else begin
                bitcnt_q <= bitcnt_q + 1'b1;
                shreg_q  <= {shreg_q[DATA_W-2:0], 1'b0};
                sda_oe_q <= ~shreg_q[DATA_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) mack_q <= ~sda_s;
            else if (scl_fall) begin
              if (mack_q) begin
                shreg_q  <= mem_rdata_i;
                sda_oe_q <= ~mem_rdata_i[DATA_W-1];
                state_q  <= ST_RDATA;
              end else begin
                sda_oe_q <= 1'b0;
                state_q  <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = sda_oe_q;
  assign mem_addr_o  = ptr;
  assign mem_we_o    = we_q;
  assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s_i,
  input logic              sda_oe_i,
  input logic              mem_we_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input tgt_state_e        state_i
);
  assert_sda_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_i != $past(sda_oe_i)) |-> !$past(scl_s_i));

  assert_we_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> !mem_we_i);

  assert_ptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> (mem_addr_i == ADDR_W'($past(mem_addr_i) + 1'b1)));

  assert_ignore_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IGNORE) |-> (!sda_oe_i && !mem_we_i));

  assert_we_from_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> ($past(state_i) == ST_WDATA));
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_oe_i(sda_oe_o),
  .mem_we_i(mem_we_o), .mem_addr_i(mem_addr_o), .state_i(state_q)
);

// File: tb/i2c_mem_target_tb_top.sv
`timescale 1ns/1ps
module i2c_mem_target_tb_top;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [6:0] DEV = 7'h52;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic sda_line;
  logic sda_oe, mwe;
  logic [ADDR_W-1:0] maddr;
  logic [7:0] mwd, mrd;
  logic [7:0] mem [DEPTH];
  logic [7:0] exp_mem [DEPTH];
  int exp_ptr = 0;
  int n_cmp = 0, n_bad = 0, we_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign sda_line = msda & ~sda_oe;

  i2c_mem_target #(.DEV_ADDR(DEV), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .mem_addr_o(maddr), .mem_we_o(mwe),
    .mem_wdata_o(mwd), .mem_rdata_i(mrd)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (mwe) mem[maddr] <= mwd;
    mrd <= mem[maddr];
    if (rst_n && mwe) we_cnt <= we_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // per-clock: SDA drive must hold while SCL is high (R9)
  logic prev_oe = 1'b0;
  int hi_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && scl && hi_cnt > 6) chk(sda_oe == prev_oe, "R9", sda_oe, prev_oe);
    prev_oe = sda_oe;
    hi_cnt  = scl ? hi_cnt + 1 : 0;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    msda = 1'b1; wt(Q); scl = 1'b1; wt(Q); msda = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    msda = 1'b0; wt(Q); scl = 1'b1; wt(Q); msda = 1'b1; wt(Q);
  endtask

  task automatic send_bit(input logic b);
    msda = b; wt(Q); scl = 1'b1; wt(2 * Q); scl = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    msda = 1'b1; wt(Q); scl = 1'b1; wt(Q);
    acked = (sda_line == 1'b0);
    wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    msda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wt(Q); scl = 1'b1; wt(Q);
      b = {b[6:0], sda_line};
      wt(Q); scl = 1'b0;
    end
    wt(Q);
    msda = ~ack; wt(Q); scl = 1'b1; wt(2 * Q); scl = 1'b0; wt(Q); msda = 1'b1;
  endtask

  task automatic cmp_mem(input string req);
    for (int i = 0; i < DEPTH; i++) chk(mem[i] == exp_mem[i], req, mem[i], exp_mem[i]);
  endtask

  task automatic wr_txn(input int a, input int n, input int seed);
    bit ak;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b0}, ak); chk(ak, "R2", ak, 1);
    send_byte(8'(a), ak);       chk(ak, "R3", ak, 1);
    exp_ptr = a;
    for (int i = 0; i < n; i++) begin
      d = 8'(seed + i * 29);
      send_byte(d, ak); chk(ak, "R3", ak, 1);
      exp_mem[exp_ptr] = d;
      exp_ptr = (exp_ptr + 1) % DEPTH;
    end
    bus_stop(); wt(4);
  endtask

  task automatic rd_body(input int n, input string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(b == exp_mem[exp_ptr], req, b, exp_mem[exp_ptr]);
      if (i < n - 1) exp_ptr = (exp_ptr + 1) % DEPTH;
    end
  endtask

  task automatic rd_cur(input int n, input string req);
    bit ak;
    bus_start();
    send_byte({DEV, 1'b1}, ak); chk(ak, "R2", ak, 1);
    rd_body(n, req);
    bus_stop(); wt(4);
  endtask

  task automatic rd_rand(input int a, input int n, input string req);
    bit ak;
    int w0;
    w0 = we_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, ak); chk(ak, "R2", ak, 1);
    send_byte(8'(a), ak);       chk(ak, "R3", ak, 1);
    exp_ptr = a;
    bus_start();
    send_byte({DEV, 1'b1}, ak); chk(ak, "R5", ak, 1);
    rd_body(n, req);
    bus_stop(); wt(4);
    chk(we_cnt == w0, "R3", we_cnt, w0); // word address alone stores nothing
  endtask

  initial begin
    bit ak;
    int w0;
    logic [7:0] b;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'(i * 7 + 3);
    wt(3);
    chk(sda_oe == 1'b0 && mwe == 1'b0, "R1", {sda_oe, mwe}, 0);
    wt(2); rst_n = 1'b1; wt(5);
    chk(sda_oe == 1'b0 && mwe == 1'b0, "R1", {sda_oe, mwe}, 0);

    wr_txn(3, 2, 8'h5A); cmp_mem("R3");
    rd_rand(3, 2, "R5");
    rd_cur(1, "R6");

    wr_txn(14, 4, 8'hC1); cmp_mem("R4");
    rd_rand(13, 6, "R7");
    rd_cur(DEPTH + 2, "R7");

    // address mismatch: no ack, no writes, pointer untouched
    w0 = we_cnt;
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, ak); chk(!ak, "R2", ak, 0);
    send_byte(8'h02, ak);               chk(!ak, "R2", ak, 0);
    send_byte(8'hEE, ak);               chk(!ak, "R2", ak, 0);
    bus_stop(); wt(4);
    chk(we_cnt == w0, "R2", we_cnt, w0);
    rd_cur(1, "R2");

    // NACK: bus released for remaining clocks, pointer not advanced
    bus_start();
    send_byte({DEV, 1'b1}, ak); chk(ak, "R2", ak, 1);
    recv_byte(1'b0, b); chk(b == exp_mem[exp_ptr], "R8", b, exp_mem[exp_ptr]);
    recv_byte(1'b0, b); chk(b == 8'hFF, "R8", b, 8'hFF);
    bus_stop(); wt(4);
    rd_cur(1, "R8");

    // STOP inside a data byte
    w0 = we_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, ak); chk(ak, "R2", ak, 1);
    send_byte(8'h08, ak);       chk(ak, "R3", ak, 1);
    exp_ptr = 8;
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop(); wt(4);
    chk(we_cnt == w0, "R10", we_cnt, w0);
    cmp_mem("R10");

    // START inside a data byte, then read at the loaded pointer
    bus_start();
    send_byte({DEV, 1'b0}, ak); chk(ak, "R2", ak, 1);
    send_byte(8'h09, ak);       chk(ak, "R3", ak, 1);
    exp_ptr = 9;
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_start();
    send_byte({DEV, 1'b1}, ak); chk(ak, "R10", ak, 1);
    rd_body(1, "R10");
    bus_stop(); wt(4);
    chk(we_cnt == w0, "R10", we_cnt, w0);
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    rd_cur(2, "R1");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule